// File: doc/BRIEF.md
# Functional-Unit Complement-Pair Guard

This block sits next to the issue selector of a processor that executes every datapath operation twice (a primary copy and a secondary copy, plus a tertiary copy that is used as a tie-breaker when the two disagree). A transient upset in a functional unit can last for several consecutive operations. If both copies of one instruction ran on the same unit inside that window, they could be corrupted in the same way and still agree. The guard prevents this. For every unit it records the most recent dispatches, each tagged with its reorder-buffer index and copy type. When the selector proposes a candidate for a unit, the guard raises a veto in the same cycle if the other copy of that instruction is still in the unit's history.

Each unit has its own idle counter. The counter restarts on every dispatch to that unit and advances on every cycle with no dispatch to it. Once the count passes a programmable limit, the unit's history is forgotten. A unit type that exists only once can therefore still run both copies, as long as a safe gap separates them. The selector can present several candidate queries at once, and each query receives its own veto bit.

Top module: `fu_pair_guard`

## Requirements
- R1: Right after reset, every unit's history is empty and no query is vetoed.
- R2: A query is vetoed when the queried unit holds a valid history entry with the same reorder-buffer index and a different copy type. The copy-type codes are 2'b01 primary, 2'b10 secondary and 2'b11 tertiary.
- R3: A query is not vetoed by an entry of the same copy type, nor by an entry with a different reorder-buffer index.
- R4: Each unit keeps only its HIST_DEPTH most recent dispatches. A new dispatch pushes out the oldest entry, which then no longer causes a veto.
- R5: When a unit receives no dispatch, its history is cleared at the clock edge where its idle count passes idleLimit. A dispatch therefore stays visible for exactly idleLimit+1 cycles after the edge that records it, if no further dispatch reaches that unit. The count saturates at its maximum.
- R6: A tertiary query is vetoed by a primary or by a secondary entry of the same index.
- R7: History is kept per unit. A dispatch to one unit never vetoes a query aimed at another unit, and every query port is evaluated independently.
- R8: The veto is combinational in the query inputs. A dispatch affects queries from the cycle after the clock edge that records it, and has no effect in its own cycle.
- R9: A dispatch on the edge where expiry would otherwise happen takes precedence. The new entry shifts in, older entries are kept, and the idle count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleLimit | input | CNT_W | Idle cycles after which a unit's history expires |
| dispValid | input | 1 | A dispatch happens this cycle |
| dispUnit | input | UNIT_W | Unit receiving the dispatch |
| dispIdx | input | IDX_W | Reorder-buffer index of the dispatched operation |
| dispType | input | 2 | Copy type of the dispatched operation |
| qryUnit | input | NUM_QRY*UNIT_W | Candidate unit for each query, query q at bits [q*UNIT_W +: UNIT_W] |
| qryIdx | input | NUM_QRY*IDX_W | Candidate reorder-buffer index for each query |
| qryType | input | NUM_QRY*2 | Candidate copy type for each query |
| qryVeto | output | NUM_QRY | Veto for each query; 1 means the candidate must not issue there |

## Verification
The hardest state to reach from the ports is the moment of expiry. A unit's history has to survive exactly idleLimit+1 quiet cycles and then vanish, and a dispatch may land on exactly that edge. The stimulus records a dispatch and then keeps the complementary copy queried on every following cycle, so the cycle in which the veto drops is observed directly. It then repeats this with a dispatch placed on the expiry edge under a short limit. A long random phase follows, using few units, a narrow range of indices and a changing limit. This makes matching indices and expiries collide often, and a behavioural model is compared against both query ports on every cycle.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  // Copy type carried with every dispatched or queried operation
  typedef enum logic [1:0] {
    COPY_NONE = 2'b00,
    COPY_PRI  = 2'b01,
    COPY_SEC  = 2'b10,
    COPY_TER  = 2'b11
  } copyType_e;

  // Per-unit strobes from control to the history datapath
  typedef struct packed {
    logic shift;  // record the current dispatch
    logic clear;  // forget the whole history of the unit
  } unitStrobe_t;

endpackage

// File: rtl/fpg_ctrl.sv
module fpg_ctrl
  import fpg_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int CNT_W     = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dispValid,
  input  logic [UNIT_W-1:0]             dispUnit,
  input  logic [CNT_W-1:0]              idleLimit,
  output unitStrobe_t [NUM_UNITS-1:0]   strb
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [CNT_W-1:0] idleCnt;
    logic             hit;

    assign hit = dispValid && (dispUnit == UNIT_W'(u));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idleCnt <= '0;
      end else if (hit) begin
        idleCnt <= '0;
      end else if (idleCnt != CNT_MAX) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end

    // Expiry: the count is about to pass the limit on this edge
    assign strb[u] = '{shift: hit, clear: !hit && (idleCnt >= idleLimit)};
  end

endmodule

// File: rtl/fpg_hist.sv
module fpg_hist
  import fpg_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int UNIT_W     = 2,
  parameter int HIST_DEPTH = 2,
  parameter int IDX_W      = 5,
  parameter int NUM_QRY    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  unitStrobe_t [NUM_UNITS-1:0]   strb,
  input  logic [IDX_W-1:0]              dispIdx,
  input  logic [1:0]                    dispType,
  input  logic [NUM_QRY*UNIT_W-1:0]     qryUnit,
  input  logic [NUM_QRY*IDX_W-1:0]      qryIdx,
  input  logic [NUM_QRY*2-1:0]          qryType,
  output logic [NUM_QRY-1:0]            qryVeto
);

  logic [IDX_W-1:0] entIdx  [NUM_UNITS][HIST_DEPTH];
  logic [1:0]       entType [NUM_UNITS][HIST_DEPTH];
  logic             entVld  [NUM_UNITS][HIST_DEPTH];

  // History shift registers, newest entry at position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        for (int k = 0; k < HIST_DEPTH; k++) begin
          entIdx[u][k]  <= '0;
          entType[u][k] <= '0;
          entVld[u][k]  <= 1'b0;
        end
      end
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (strb[u].shift) begin
          entIdx[u][0]  <= dispIdx;
          entType[u][0] <= dispType;
          entVld[u][0]  <= 1'b1;
          for (int k = 1; k < HIST_DEPTH; k++) begin
            entIdx[u][k]  <= entIdx[u][k-1];
            entType[u][k] <= entType[u][k-1];
            entVld[u][k]  <= entVld[u][k-1];
          end
        end else if (strb[u].clear) begin
          for (int k = 0; k < HIST_DEPTH; k++) begin
            entVld[u][k] <= 1'b0;
          end
        end
      end
    end
  end

  // One comparator bank per query port
  for (genvar q = 0; q < NUM_QRY; q++) begin : g_qry
    logic [UNIT_W-1:0] qU;
    logic [IDX_W-1:0]  qI;
    logic [1:0]        qT;
    logic              clash;

    assign qU = qryUnit[q*UNIT_W +: UNIT_W];
    assign qI = qryIdx[q*IDX_W +: IDX_W];
    assign qT = qryType[q*2 +: 2];

    always_comb begin
      clash = 1'b0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        for (int k = 0; k < HIST_DEPTH; k++) begin
          if ((UNIT_W'(u) == qU) && entVld[u][k] &&
              (entIdx[u][k] == qI) && (entType[u][k] != qT)) begin
            clash = 1'b1;
          end
        end
      end
    end

    assign qryVeto[q] = clash;
  end

endmodule

// File: rtl/fu_pair_guard.sv
module fu_pair_guard
  import fpg_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int HIST_DEPTH = 2,
  parameter int IDX_W      = 5,
  parameter int CNT_W      = 6,
  parameter int NUM_QRY    = 2,
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CNT_W-1:0]          idleLimit,
  input  logic                      dispValid,
  input  logic [UNIT_W-1:0]         dispUnit,
  input  logic [IDX_W-1:0]          dispIdx,
  input  logic [1:0]                dispType,
  input  logic [NUM_QRY*UNIT_W-1:0] qryUnit,
  input  logic [NUM_QRY*IDX_W-1:0]  qryIdx,
  input  logic [NUM_QRY*2-1:0]      qryType,
  output logic [NUM_QRY-1:0]        qryVeto
);

  unitStrobe_t [NUM_UNITS-1:0] strb;
  logic        [NUM_UNITS-1:0] clrVec;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_clr
    assign clrVec[u] = strb[u].clear;
  end

  fpg_ctrl #(
    .NUM_UNITS (NUM_UNITS),
    .UNIT_W    (UNIT_W),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .dispValid (dispValid),
    .dispUnit  (dispUnit),
    .idleLimit (idleLimit),
    .strb      (strb)
  );

  fpg_hist #(
    .NUM_UNITS  (NUM_UNITS),
    .UNIT_W     (UNIT_W),
    .HIST_DEPTH (HIST_DEPTH),
    .IDX_W      (IDX_W),
    .NUM_QRY    (NUM_QRY)
  ) hist_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dispIdx  (dispIdx),
    .dispType (dispType),
    .qryUnit  (qryUnit),
    .qryIdx   (qryIdx),
    .qryType  (qryType),
    .qryVeto  (qryVeto)
  );

endmodule

// File: rtl/fpg_chk.sv
module fpg_chk #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int IDX_W     = 5,
  parameter int NUM_QRY   = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      dispValid,
  input logic [UNIT_W-1:0]         dispUnit,
  input logic [IDX_W-1:0]          dispIdx,
  input logic [1:0]                dispType,
  input logic [NUM_QRY*UNIT_W-1:0] qryUnit,
  input logic [NUM_QRY*IDX_W-1:0]  qryIdx,
  input logic [NUM_QRY*2-1:0]      qryType,
  input logic [NUM_QRY-1:0]        qryVeto,
  input logic [NUM_UNITS-1:0]      clrVec
);

  logic [UNIT_W-1:0] qU0;
  logic [IDX_W-1:0]  qI0;
  logic [1:0]        qT0;

  assign qU0 = qryUnit[UNIT_W-1:0];
  assign qI0 = qryIdx[IDX_W-1:0];
  assign qT0 = qryType[1:0];

  // R1: the first cycle after reset sees empty histories
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (qryVeto == '0));

  // R2: the complement of the dispatch one edge ago is always vetoed
  p_recent_veto_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(dispValid) && (qU0 == $past(dispUnit)) &&
     (qI0 == $past(dispIdx)) && (qT0 != $past(dispType))) |-> qryVeto[0]);

  // R6: a tertiary candidate is blocked by a fresh primary or secondary
  p_tert_veto_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(dispValid) && (qU0 == $past(dispUnit)) &&
     (qI0 == $past(dispIdx)) && (qT0 == 2'b11) &&
     ($past(dispType) != 2'b11)) |-> qryVeto[0]);

  // R5: a unit whose history was just cleared cannot veto
  p_expired_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (($past(clrVec) & (NUM_UNITS'(1) << qU0)) != '0))
      |-> !qryVeto[0]);

  // R9: expiry never coincides with a dispatch to the same unit
  p_clear_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> !clrVec[dispUnit]);

endmodule

bind fu_pair_guard fpg_chk #(
  .NUM_UNITS (NUM_UNITS),
  .UNIT_W    (UNIT_W),
  .IDX_W     (IDX_W),
  .NUM_QRY   (NUM_QRY)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .dispValid (dispValid),
  .dispUnit  (dispUnit),
  .dispIdx   (dispIdx),
  .dispType  (dispType),
  .qryUnit   (qryUnit),
  .qryIdx    (qryIdx),
  .qryType   (qryType),
  .qryVeto   (qryVeto),
  .clrVec    (clrVec)
);

// File: tb/fu_pair_guard_tb_top.sv
`timescale 1ns/1ps
module fu_pair_guard_tb_top;

  localparam int NU    = 4;
  localparam int DEPTH = 2;
  localparam int IW    = 5;
  localparam int CW    = 6;
  localparam int NQ    = 2;
  localparam int UW    = 2;
  localparam int CMAX  = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [CW-1:0]   idleLimit = '0;
  logic            dispValid = 1'b0;
  logic [UW-1:0]   dispUnit = '0;
  logic [IW-1:0]   dispIdx = '0;
  logic [1:0]      dispType = '0;
  logic [NQ*UW-1:0] qryUnit = '0;
  logic [NQ*IW-1:0] qryIdx = '0;
  logic [NQ*2-1:0]  qryType = '0;
  logic [NQ-1:0]    qryVeto;

  int errors = 0;
  int checks = 0;

  // behavioural model state
  int hIdx [NU][DEPTH];
  int hTyp [NU][DEPTH];
  bit hVld [NU][DEPTH];
  int idle [NU];

  always #2.5 clk = ~clk;  // 200 MHz

  fu_pair_guard #(
    .NUM_UNITS(NU), .HIST_DEPTH(DEPTH), .IDX_W(IW), .CNT_W(CW), .NUM_QRY(NQ)
  ) dut_i (
    .clk(clk), .rstN(rstN), .idleLimit(idleLimit),
    .dispValid(dispValid), .dispUnit(dispUnit), .dispIdx(dispIdx), .dispType(dispType),
    .qryUnit(qryUnit), .qryIdx(qryIdx), .qryType(qryType), .qryVeto(qryVeto)
  );

  task automatic model_reset();
    for (int u = 0; u < NU; u++) begin
      idle[u] = 0;
      for (int k = 0; k < DEPTH; k++) begin
        hVld[u][k] = 1'b0; hIdx[u][k] = 0; hTyp[u][k] = 0;
      end
    end
  endtask

  function automatic bit model_veto(int u, int i, int t);
    bit v = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if (hVld[u][k] && hIdx[u][k] == i && hTyp[u][k] != t) v = 1'b1;
    return v;
  endfunction

  // model update for one clock edge, using the inputs that were applied
  task automatic model_edge(bit dv, int du, int di, int dt, int lim);
    for (int u = 0; u < NU; u++) begin
      if (dv && du == u) begin
        for (int k = DEPTH - 1; k > 0; k--) begin
          hVld[u][k] = hVld[u][k-1]; hIdx[u][k] = hIdx[u][k-1]; hTyp[u][k] = hTyp[u][k-1];
        end
        hVld[u][0] = 1'b1; hIdx[u][0] = di; hTyp[u][0] = dt;
        idle[u] = 0;
      end else begin
        if (idle[u] >= lim)
          for (int k = 0; k < DEPTH; k++) hVld[u][k] = 1'b0;
        if (idle[u] < CMAX) idle[u] = idle[u] + 1;
      end
    end
  endtask

  // drive the queries and compare both veto bits within the current cycle
  task automatic probe(int qu0, int qi0, int qt0, int qu1, int qi1, int qt1, string tag);
    bit exp0, exp1;
    qryUnit = {UW'(qu1), UW'(qu0)};
    qryIdx  = {IW'(qi1), IW'(qi0)};
    qryType = {2'(qt1), 2'(qt0)};
    #1;
    exp0 = model_veto(qu0, qi0, qt0);
    exp1 = model_veto(qu1, qi1, qt1);
    checks++;
    if (qryVeto[0] !== exp0) begin
      errors++;
      $display("FAIL %s query0 u%0d idx%0d t%0d: veto=%b expected %b", tag, qu0, qi0, qt0, qryVeto[0], exp0);
    end
    checks++;
    if (qryVeto[1] !== exp1) begin
      errors++;
      $display("FAIL %s query1 u%0d idx%0d t%0d: veto=%b expected %b", tag, qu1, qi1, qt1, qryVeto[1], exp1);
    end
  endtask

  task automatic step(bit dv, int du, int di, int dt,
                      int qu0, int qi0, int qt0, int qu1, int qi1, int qt1, string tag);
    @(negedge clk);
    dispValid = dv; dispUnit = UW'(du); dispIdx = IW'(di); dispType = 2'(dt);
    probe(qu0, qi0, qt0, qu1, qi1, qt1, tag);
    @(posedge clk);
    model_edge(dv, du, di, dt, int'(idleLimit));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    model_reset();
    idleLimit = CW'(3);
    repeat (3) @(posedge clk);
    // R1: empty history during and right after reset
    @(negedge clk);
    probe(1, 5, 2, 2, 5, 1, "R1");
    rstN = 1'b1;
    step(0, 0, 0, 0, 1, 5, 2, 0, 0, 3, "R1");

    // R8: dispatch has no effect in its own cycle
    step(1, 1, 5, 1, 1, 5, 2, 1, 5, 3, "R8");
    // R2 / R3 / R7: complement vetoed, same type and other unit not
    step(0, 0, 0, 0, 1, 5, 2, 1, 5, 1, "R2");
    step(0, 0, 0, 0, 2, 5, 2, 1, 6, 2, "R7");
    // R8: queries changed inside one cycle answer at once
    @(negedge clk);
    probe(1, 5, 3, 1, 4, 2, "R8");
    probe(1, 5, 1, 1, 5, 2, "R3");
    @(posedge clk);
    model_edge(0, 0, 0, 0, int'(idleLimit));

    // R6: tertiary blocked by a secondary entry
    step(1, 2, 7, 2, 0, 0, 1, 0, 0, 1, "R6");
    step(0, 0, 0, 0, 2, 7, 3, 2, 7, 2, "R6");

    // R4: depth limit pushes the oldest entry out
    step(1, 0, 1, 1, 0, 1, 2, 0, 2, 2, "R4");
    step(1, 0, 2, 1, 0, 1, 2, 0, 2, 2, "R4");
    step(1, 0, 3, 1, 0, 1, 2, 0, 2, 2, "R4");
    step(0, 0, 0, 0, 0, 1, 2, 0, 3, 2, "R4");

    // R5: history expires after idleLimit+1 quiet cycles
    step(1, 3, 9, 1, 3, 9, 2, 3, 9, 3, "R5");
    for (int c = 0; c < 7; c++) step(0, 0, 0, 0, 3, 9, 2, 3, 9, 3, "R5");

    // R9: dispatch on the expiry edge keeps older entries
    idleLimit = CW'(1);
    step(1, 1, 12, 1, 1, 12, 2, 1, 13, 2, "R9");
    step(0, 0, 0, 0, 1, 12, 2, 1, 13, 2, "R9");
    step(1, 1, 13, 2, 1, 12, 2, 1, 13, 1, "R9");
    step(0, 0, 0, 0, 1, 12, 2, 1, 13, 1, "R9");
    step(0, 0, 0, 0, 1, 12, 2, 1, 13, 1, "R9");
    step(0, 0, 0, 0, 1, 12, 2, 1, 13, 1, "R9");

    // mixed random traffic over all rules
    for (int c = 0; c < 600; c++) begin
      if (c % 50 == 0) idleLimit = CW'($urandom_range(0, 4));
      step($urandom_range(0, 3) != 0, $urandom_range(0, NU - 1), $urandom_range(0, 3),
           $urandom_range(1, 3),
           $urandom_range(0, NU - 1), $urandom_range(0, 3), $urandom_range(1, 3),
           $urandom_range(0, NU - 1), $urandom_range(0, 3), $urandom_range(1, 3), "R2");
    end

    // R1: a second reset empties every history
    @(negedge clk);
    rstN = 1'b0;
    dispValid = 1'b0;
    model_reset();
    #1;
    @(negedge clk);
    rstN = 1'b1;
    probe(0, 1, 2, 1, 2, 3, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule